// File: doc/BRIEF.md
# Burst Transmit Scheduler

This block sits at the output of an optical burst edge node, behind a set of aggregation buffers. When a buffer has finished assembling a burst, it raises a one-cycle send request. The request carries the burst type, the number of packets in the burst and the payload length in words. The request is not a control packet. The scheduler stores its fields and starts work only when the output port reports that it is free. Pending requests from different buffers are served in round-robin order, and a stored request stays pending until it is granted.

Once a request is granted, the scheduler sends one control header word on the output. That word carries the offset delay, which is fixed at this point. The scheduler then waits for the offset number of cycles. After that it sends a burst header word built from the stored fields, followed by the payload words, which it pulls one per cycle from the owning buffer. The owning buffer gets a one-cycle response in the burst header cycle. A done pulse marks the final word. Requests that arrive while a burst is in flight are stored and served afterwards.

The control sequence has five states:

- ST_IDLE waits for a pending request while the port is free (transition: grant, to ST_CTRL).
- ST_CTRL sends the control header. It moves to ST_HDR when the effective offset is 1, and to ST_OFFSET otherwise.
- ST_OFFSET counts down the rest of the offset (transition: expiry, to ST_HDR).
- ST_HDR sends the burst header and the response. It returns to ST_IDLE for an empty payload and moves to ST_PAYLOAD otherwise.
- ST_PAYLOAD streams the words (transition: last word, to ST_IDLE).

Top module: `burst_tx_sched`

## Requirements
- R1: After reset, tx_valid, ack, buf_rd and done are all low, and no word is sent until a request arrives.
- R2: A request is stored when req_valid pulses for its source, and it stays pending while port_idle is low. No word is sent until port_idle is high while the scheduler is idle.
- R3: The first word of a burst has tx_kind 0, the control header. Its tx_data holds the effective offset in bits [11:0], the payload length in bits [23:12] and the burst type in bits [31:24].
- R4: The effective offset is offset_cfg, with a value of 0 treated as 1. The burst header appears exactly that many cycles after the control header, with tx_valid low in between.
- R5: The burst header has tx_kind 1. Its tx_data holds the payload length in bits [11:0], the packet count in bits [19:12], the burst type in bits [27:20], and zero above.
- R6: The payload words (tx_kind 2) follow the burst header on consecutive cycles, one word per unit of payload length. Each carries buf_dout of the owning source, and buf_rd is asserted for that source only, in those cycles only.
- R7: ack is a one-cycle pulse, asserted only for the owning source and only in the burst header cycle.
- R8: done is high for one cycle, together with the last payload word, or together with the burst header when the payload length is 0.
- R9: Among pending sources, the next grant goes to the first one at or after the position just past the previously granted source, wrapping around. The search starts at source 0 after reset.
- R10: Requests that arrive while a burst is being timed or sent are stored but not started. The next control header appears only after the current burst's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_SRC | One-cycle send request per source |
| req_type | input | NUM_SRC*TYPE_W | Burst type per source |
| req_count | input | NUM_SRC*CNT_W | Packet count per source |
| req_len | input | NUM_SRC*LEN_W | Payload length in words per source |
| offset_cfg | input | OFS_W | Offset delay in cycles (0 acts as 1) |
| port_idle | input | 1 | Output port free to start a burst |
| buf_dout | input | NUM_SRC*DATA_W | Head payload word of each buffer, show-ahead |
| buf_rd | output | NUM_SRC | Pop strobe to the owning buffer |
| ack | output | NUM_SRC | Response pulse to the owning buffer |
| tx_valid | output | 1 | Output word valid |
| tx_kind | output | 2 | 0 control header, 1 burst header, 2 payload |
| tx_data | output | DATA_W | Output word |
| done | output | 1 | Last word of the burst |

## Verification
A wrong internal state appears at the ports within a cycle or two. A stale or mis-set round-robin pointer shows up as bursts arriving in the wrong source order. A wrong offset count shifts the burst header away from its expected distance after the control header. A wrong word counter shows up as a payload that is too short or too long, or as done landing on the wrong word. Latching the wrong request fields corrupts the header words. The scoreboard compares every output word, its spacing from the previous word, and the ack, done and buf_rd strobes as they appear. Idle cycles are checked for stray strobes.

// File: rtl/burst_tx_pkg.sv
package burst_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_OFFSET,
        ST_HDR,
        ST_PAYLOAD
    } sched_state_t;

    typedef enum logic [1:0] {
        KIND_CTRL = 2'd0,
        KIND_HDR  = 2'd1,
        KIND_PAY  = 2'd2
    } word_kind_t;
endpackage

// File: rtl/bts_req_store.sv
module bts_req_store #(
    parameter int NUM_SRC = 4,
    parameter int TYPE_W  = 8,
    parameter int CNT_W   = 8,
    parameter int LEN_W   = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          req_valid,
    input  logic [NUM_SRC*TYPE_W-1:0]   req_type,
    input  logic [NUM_SRC*CNT_W-1:0]    req_count,
    input  logic [NUM_SRC*LEN_W-1:0]    req_len,
    input  logic [NUM_SRC-1:0]          take,
    input  logic [$clog2(NUM_SRC)-1:0]  sel_idx,
    output logic [NUM_SRC-1:0]          pending,
    output logic [TYPE_W-1:0]           sel_type,
    output logic [CNT_W-1:0]            sel_count,
    output logic [LEN_W-1:0]            sel_len
);
    logic [NUM_SRC*TYPE_W-1:0] type_flat;
    logic [NUM_SRC*CNT_W-1:0]  count_flat;
    logic [NUM_SRC*LEN_W-1:0]  len_flat;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_slot
        logic              pend_r;
        logic [TYPE_W-1:0] type_r;
        logic [CNT_W-1:0]  count_r;
        logic [LEN_W-1:0]  len_r;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_r  <= 1'b0;
                type_r  <= '0;
                count_r <= '0;
                len_r   <= '0;
            end else begin
                if (take[g]) begin
                    pend_r <= 1'b0;
                end else if (req_valid[g]) begin
                    pend_r <= 1'b1;
                end
                if (req_valid[g] && !pend_r) begin
                    type_r  <= req_type[g*TYPE_W +: TYPE_W];
                    count_r <= req_count[g*CNT_W +: CNT_W];
                    len_r   <= req_len[g*LEN_W +: LEN_W];
                end
            end
        end

        assign pending[g]                        = pend_r;
        assign type_flat[g*TYPE_W +: TYPE_W]     = type_r;
        assign count_flat[g*CNT_W +: CNT_W]      = count_r;
        assign len_flat[g*LEN_W +: LEN_W]        = len_r;
    end

    assign sel_type  = type_flat[sel_idx*TYPE_W +: TYPE_W];
    assign sel_count = count_flat[sel_idx*CNT_W +: CNT_W];
    assign sel_len   = len_flat[sel_idx*LEN_W +: LEN_W];
endmodule

// File: rtl/bts_rr_arbiter.sv
module bts_rr_arbiter #(
    parameter int NUM_SRC = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          pending,
    input  logic                        advance,
    output logic [NUM_SRC-1:0]          grant,
    output logic [$clog2(NUM_SRC)-1:0]  grant_idx,
    output logic                        any
);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [IDX_W-1:0] ptr_q;

    always_comb begin
        int cand;
        grant_idx = '0;
        any       = 1'b0;
        for (int off = 0; off < NUM_SRC; off++) begin
            cand = int'(ptr_q) + off;
            if (cand >= NUM_SRC) begin
                cand = cand - NUM_SRC;
            end
            if (!any && pending[cand]) begin
                any       = 1'b1;
                grant_idx = IDX_W'(cand);
            end
        end
        grant = any ? (NUM_SRC'(1) << grant_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance && any) begin
            ptr_q <= (grant_idx == IDX_W'(NUM_SRC - 1)) ? '0 : grant_idx + 1'b1;
        end
    end
endmodule

// File: rtl/bts_offset_timer.sv
module bts_offset_timer #(
    parameter int OFS_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFS_W-1:0] cfg_offset,
    input  logic             load,
    input  logic             tick,
    output logic [OFS_W-1:0] ofs_eff,
    output logic             single,
    output logic             last
);
    logic [OFS_W-1:0] cnt_q;

    assign ofs_eff = (cfg_offset == '0) ? OFS_W'(1) : cfg_offset;
    assign single  = (ofs_eff == OFS_W'(1));
    assign last    = (cnt_q == OFS_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= ofs_eff - OFS_W'(1);
        end else if (tick && cnt_q != '0) begin
            cnt_q <= cnt_q - OFS_W'(1);
        end
    end
endmodule

// File: rtl/burst_tx_sched.sv
module burst_tx_sched
    import burst_tx_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DATA_W  = 32,
    parameter int TYPE_W  = 8,
    parameter int CNT_W   = 8,
    parameter int LEN_W   = 12,
    parameter int OFS_W   = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        req_valid,
    input  logic [NUM_SRC*TYPE_W-1:0] req_type,
    input  logic [NUM_SRC*CNT_W-1:0]  req_count,
    input  logic [NUM_SRC*LEN_W-1:0]  req_len,
    input  logic [OFS_W-1:0]          offset_cfg,
    input  logic                      port_idle,
    input  logic [NUM_SRC*DATA_W-1:0] buf_dout,
    output logic [NUM_SRC-1:0]        buf_rd,
    output logic [NUM_SRC-1:0]        ack,
    output logic                      tx_valid,
    output logic [1:0]                tx_kind,
    output logic [DATA_W-1:0]         tx_data,
    output logic                      done
);
    localparam int IDX_W = $clog2(NUM_SRC);
    localparam int CTRL_BITS = TYPE_W + LEN_W + OFS_W;
    localparam int HDR_BITS  = TYPE_W + CNT_W + LEN_W;

    sched_state_t state_q, state_d;

    logic [NUM_SRC-1:0] pending, arb_grant, take;
    logic [IDX_W-1:0]   arb_idx, owner_q;
    logic               arb_any, start;
    logic [TYPE_W-1:0]  sel_type, cur_type_q;
    logic [CNT_W-1:0]   sel_count, cur_count_q;
    logic [LEN_W-1:0]   sel_len, cur_len_q, wcnt_q;
    logic [OFS_W-1:0]   ofs_eff;
    logic               tmr_single, tmr_last;

    assign start = (state_q == ST_IDLE) && arb_any && port_idle;
    assign take  = start ? arb_grant : '0;

    bts_req_store #(
        .NUM_SRC(NUM_SRC), .TYPE_W(TYPE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_type(req_type),
        .req_count(req_count), .req_len(req_len),
        .take(take), .sel_idx(arb_idx),
        .pending(pending), .sel_type(sel_type),
        .sel_count(sel_count), .sel_len(sel_len)
    );

    bts_rr_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
        .clk(clk), .rst_n(rst_n),
        .pending(pending), .advance(start),
        .grant(arb_grant), .grant_idx(arb_idx), .any(arb_any)
    );

    bts_offset_timer #(.OFS_W(OFS_W)) tmr_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_offset(offset_cfg),
        .load(state_q == ST_CTRL),
        .tick(state_q == ST_OFFSET),
        .ofs_eff(ofs_eff), .single(tmr_single), .last(tmr_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Burst context and payload word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q     <= '0;
            cur_type_q  <= '0;
            cur_count_q <= '0;
            cur_len_q   <= '0;
            wcnt_q      <= '0;
        end else begin
            if (start) begin
                owner_q     <= arb_idx;
                cur_type_q  <= sel_type;
                cur_count_q <= sel_count;
                cur_len_q   <= sel_len;
            end
            if (state_q == ST_HDR) begin
                wcnt_q <= cur_len_q;
            end else if (state_q == ST_PAYLOAD) begin
                wcnt_q <= wcnt_q - LEN_W'(1);
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_CTRL;
            ST_CTRL:    state_d = tmr_single ? ST_HDR : ST_OFFSET;
            ST_OFFSET:  if (tmr_last) state_d = ST_HDR;
            ST_HDR:     state_d = (cur_len_q == '0) ? ST_IDLE : ST_PAYLOAD;
            ST_PAYLOAD: if (wcnt_q == LEN_W'(1)) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_kind  = KIND_CTRL;
        tx_data  = '0;
        buf_rd   = '0;
        ack      = '0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_OFFSET: begin
            end
            ST_CTRL: begin
                tx_valid = 1'b1;
                tx_kind  = KIND_CTRL;
                tx_data  = DATA_W'(CTRL_BITS'({cur_type_q, cur_len_q, ofs_eff}));
            end
            ST_HDR: begin
                tx_valid = 1'b1;
                tx_kind  = KIND_HDR;
                tx_data  = DATA_W'(HDR_BITS'({cur_type_q, cur_count_q, cur_len_q}));
                ack      = NUM_SRC'(1) << owner_q;
                done     = (cur_len_q == '0);
            end
            ST_PAYLOAD: begin
                tx_valid = 1'b1;
                tx_kind  = KIND_PAY;
                tx_data  = buf_dout[owner_q*DATA_W +: DATA_W];
                buf_rd   = NUM_SRC'(1) << owner_q;
                done     = (wcnt_q == LEN_W'(1));
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/burst_tx_sched_chk.sv
module burst_tx_sched_chk #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               port_idle,
    input logic [NUM_SRC-1:0] buf_rd,
    input logic [NUM_SRC-1:0] ack,
    input logic               tx_valid,
    input logic [1:0]         tx_kind,
    input logic               done
);
    a_r6_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(buf_rd));
    a_r6_rd_with_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd != '0) |-> (tx_valid && tx_kind == 2'd2));
    a_r7_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));
    a_r7_ack_in_header: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != '0) |-> (tx_valid && tx_kind == 2'd1));
    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != '0) |=> (ack == '0));
    a_r8_done_with_word: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tx_valid && tx_kind != 2'd0));
    a_r4_ctrl_then_gap_or_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_kind == 2'd0) |=> (!tx_valid || tx_kind == 2'd1));
    a_r2_ctrl_needs_idle_port: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_kind == 2'd0) |-> $past(port_idle));
endmodule

bind burst_tx_sched burst_tx_sched_chk #(.NUM_SRC(NUM_SRC)) chk_i (
    .clk(clk), .rst_n(rst_n), .port_idle(port_idle),
    .buf_rd(buf_rd), .ack(ack), .tx_valid(tx_valid),
    .tx_kind(tx_kind), .done(done)
);

// File: tb/burst_tx_sched_tb_top.sv
`timescale 1ns/1ps
module burst_tx_sched_tb_top;
    localparam int K = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [K-1:0]    req_valid = '0;
    logic [K*8-1:0]  req_type  = '0;
    logic [K*8-1:0]  req_count = '0;
    logic [K*12-1:0] req_len   = '0;
    logic [11:0]     offset_cfg = 12'd3;
    logic            port_idle = 1'b1;
    logic [K*32-1:0] buf_dout;
    logic [K-1:0]    buf_rd, ack;
    logic            tx_valid, done;
    logic [1:0]      tx_kind;
    logic [31:0]     tx_data;

    always #4 clk = ~clk;

    burst_tx_sched dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
        .req_count(req_count), .req_len(req_len), .offset_cfg(offset_cfg),
        .port_idle(port_idle), .buf_dout(buf_dout), .buf_rd(buf_rd), .ack(ack),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_data(tx_data), .done(done)
    );

    // Show-ahead buffer model: word = {source, read index}
    logic [23:0] rd_idx [K];
    for (genvar g = 0; g < K; g++) begin : g_buf
        assign buf_dout[g*32 +: 32] = {8'(g), rd_idx[g]};
        always @(posedge clk) begin
            if (!rst_n) rd_idx[g] <= '0;
            else if (buf_rd[g]) rd_idx[g] <= rd_idx[g] + 24'd1;
        end
    end

    typedef struct {
        logic [1:0]   kind;
        logic [31:0]  data;
        logic [K-1:0] ack;
        logic         done;
        logic [K-1:0] rd;
        int           gap;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int last_cyc = 0;
    int nvalid = 0;
    int exp_idx [K];

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_burst(int src, logic [7:0] typ, logic [7:0] cnt,
                                logic [11:0] len, int ofs);
        int oe = (ofs == 0) ? 1 : ofs;
        exp_t e;
        e = '{kind: 2'd0, data: {typ, len, 12'(oe)}, ack: '0, done: 1'b0,
              rd: '0, gap: -1, tag: "R3"};
        exp_q.push_back(e);
        e = '{kind: 2'd1, data: {4'h0, typ, cnt, len}, ack: K'(1) << src,
              done: (len == 0), rd: '0, gap: oe, tag: "R5"};
        exp_q.push_back(e);
        for (int k = 0; k < int'(len); k++) begin
            e = '{kind: 2'd2, data: {8'(src), 24'(exp_idx[src])}, ack: '0,
                  done: (k == int'(len) - 1), rd: K'(1) << src, gap: 1, tag: "R6"};
            exp_q.push_back(e);
            exp_idx[src]++;
        end
    endtask

    task automatic set_req(int src, logic [7:0] typ, logic [7:0] cnt, logic [11:0] len);
        req_type[src*8 +: 8]   = typ;
        req_count[src*8 +: 8]  = cnt;
        req_len[src*12 +: 12]  = len;
    endtask

    task automatic pulse(logic [K-1:0] mask);
        @(negedge clk);
        req_valid = mask;
        @(negedge clk);
        req_valid = '0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (tx_valid) begin
                int gap;
                exp_t e;
                gap = cyc - last_cyc;
                last_cyc = cyc;
                nvalid++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected word", tx_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(tx_kind == e.kind, e.tag, "kind", tx_kind, e.kind);
                    check(tx_data == e.data, e.tag, "data", tx_data, e.data);
                    check(ack == e.ack, "R7", "ack", ack, e.ack);
                    check(done == e.done, "R8", "done", done, e.done);
                    check(buf_rd == e.rd, "R6", "buf_rd", buf_rd, e.rd);
                    if (e.gap >= 0)
                        check(gap == e.gap, (e.kind == 2'd1) ? "R4" : "R6", "gap",
                              gap, e.gap);
                end
            end else begin
                check(ack == '0 && done == 1'b0 && buf_rd == '0, "R7",
                      "strobe while idle", {ack, done, buf_rd}, 0);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seen;
        for (int i = 0; i < K; i++) exp_idx[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_valid == 0 && ack == 0 && buf_rd == 0 && done == 0, "R1",
              "reset outputs", {tx_valid, ack, buf_rd, done}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(nvalid == 0, "R1", "word without request", nvalid, 0);

        // Single burst from source 1, offset 3
        offset_cfg = 12'd3;
        set_req(1, 8'h11, 8'd3, 12'd4);
        expect_burst(1, 8'h11, 8'd3, 12'd4, 3);
        pulse(4'b0010);
        drain();

        // R2: three requests held while port busy; R9 order 2,3,0
        port_idle = 1'b0;
        set_req(0, 8'hA0, 8'd1, 12'd2);
        set_req(2, 8'hA2, 8'd5, 12'd3);
        set_req(3, 8'hA3, 8'd7, 12'd1);
        seen = nvalid;
        pulse(4'b1101);
        repeat (20) @(negedge clk);
        check(nvalid == seen, "R2", "words while port busy", nvalid - seen, 0);
        expect_burst(2, 8'hA2, 8'd5, 12'd3, 3); // R9 first after pointer 2
        expect_burst(3, 8'hA3, 8'd7, 12'd1, 3);
        expect_burst(0, 8'hA0, 8'd1, 12'd2, 3); // R9 wrap
        port_idle = 1'b1;
        drain();

        // R4: offset 0 acts as 1; R8 empty payload done on header
        offset_cfg = 12'd0;
        set_req(3, 8'h5C, 8'd0, 12'd0);
        expect_burst(3, 8'h5C, 8'd0, 12'd0, 0);
        pulse(4'b1000);
        drain();

        // R10: request during a burst is stored and served after done
        offset_cfg = 12'd5;
        set_req(0, 8'h70, 8'd2, 12'd6);
        set_req(1, 8'h71, 8'd4, 12'd2);
        expect_burst(0, 8'h70, 8'd2, 12'd6, 5);
        expect_burst(1, 8'h71, 8'd4, 12'd2, 5);
        pulse(4'b0001);
        repeat (2) @(negedge clk);
        pulse(4'b0010);
        drain();

        check(exp_q.size() == 0, "R10", "leftover expected words", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule